// File: doc/BRIEF.md
# Serial ADC Acquisition Controller

This block is the host-side sequencer for a serial sampling converter. It has a conversion-start line, a conversion-in-progress flag and a serial data output. On a start request, or on its own timer when continuous running is enabled, the controller shapes the start line for one conversion. It then waits for the converter to report the end of conversion, clocks out one 16-bit frame and hands back the low 12 bits with a one-cycle strobe.

Two power modes are supported. In high-sampling mode the start line idles high. A short low pulse begins the conversion, and the line is already high again when the conversion ends. In auto-sleep mode the start line idles low so that the converter sleeps between conversions. The controller raises the line for a wake interval and then drops it to begin the conversion, and keeps it low through the end of conversion. Every duration is a parameter counted in system clock cycles. A quiet interval always separates the last serial clock of a read from the next start edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and immediately after it, `convst` is 1, `sclk` is 0, `sample_vld` is 0 and `conv_err` is 0.
- R2: With `sleep_mode` = 0 (high-sampling) latched at start, `convst` goes low for exactly `T_LOW` cycles, then returns high and is high when the converter's `busy` falls.
- R3: With `sleep_mode` = 1 (auto-sleep) latched at start, `convst` is high for exactly `T_WAKE` cycles when it idled low beforehand. It then falls and stays low through the fall of `busy` and afterwards while idle.
- R4: No `sclk` edge occurs while `busy` is high. A read starts only after `busy` has been seen high and then low.
- R5: A read is exactly 16 `sclk` periods, each `SCLK_HALF` cycles low followed by `SCLK_HALF` cycles high, with `sdata` captured as `sclk` rises.
- R6: The first received bit is the most significant of the 16. `sample` carries bits 11..0 of the frame, and `sample_vld` is high for exactly one cycle per completed read.
- R7: At least `T_QUIET` cycles pass between the last falling edge of `sclk` and the next falling edge of `convst`.
- R8: `convst` does not change while a read is clocking `sclk`.
- R9: If `busy` fails to complete its high-then-low cycle within `BUSY_TMO` cycles of the conversion start edge, `conv_err` is set, no sample is reported and the controller returns to idle. `conv_err` is cleared by the next accepted start.
- R10: With `run_en` = 1, successive conversion start edges are spaced exactly max(`run_period`, MIN_PERIOD) cycles apart, provided one conversion fits in that spacing. MIN_PERIOD = `T_LOW` + `T_CONV` + 32·`SCLK_HALF` + `T_QUIET`.
- R11: The power mode is taken from `sleep_mode` only when a conversion is accepted. Changes during a conversion take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Single conversion request, accepted when idle |
| run_en | input | 1 | Repeat conversions at the programmed spacing |
| sleep_mode | input | 1 | 0 = high-sampling, 1 = auto-sleep |
| run_period | input | PERIOD_W | Requested start-to-start spacing in cycles |
| busy | input | 1 | Converter conversion-in-progress flag (asynchronous) |
| sdata | input | 1 | Converter serial data |
| convst | output | 1 | Conversion start / power control line |
| sclk | output | 1 | Serial clock to the converter |
| sample | output | SAMPLE_W | Last received sample |
| sample_vld | output | 1 | One-cycle strobe for a new sample |
| conv_err | output | 1 | Conversion end not seen in time |

## Verification
The bench builds the controller with `T_LOW`=3, `T_WAKE`=10, `T_CONV`=20, `SCLK_HALF`=2, `T_QUIET`=6 and `BUSY_TMO`=60. With these values a full conversion and read takes about a hundred cycles. This brings the timeout, the 93-cycle throughput floor and a 200-cycle programmed spacing into a short run. The converter model answers each start edge with a 20-cycle `busy` pulse and a random 16-bit frame. It can hold `busy` high to force the timeout. Random sequences of high-sampling and auto-sleep conversions cover every mode transition, including a mode input flipped mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start request or pacer tick
        ST_ARM,    // high-sampling start from a low idle line: raise first
        ST_LOW,    // high-sampling start pulse, line low
        ST_WAKE,   // auto-sleep wake interval, line high
        ST_WAIT,   // waiting for busy high then low
        ST_READ,   // serial frame in progress
        ST_QUIET   // guard interval before the next start edge
    } seq_state_t;

    typedef enum logic {
        MODE_FAST  = 1'b0,
        MODE_SLEEP = 1'b1
    } pwr_mode_t;

    // Per-conversion result handed from the FSM to the output registers
    typedef struct packed {
        logic vld;
        logic err;
    } conv_flags_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Level the start line rests at between conversions
    function automatic logic idle_level(input pwr_mode_t m);
        return (m == MODE_FAST);
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int HALF   = 4,
    parameter int NBITS  = 16,
    parameter int OUT_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             sdata,
    output logic             sclk,
    output logic             done,
    output logic [OUT_W-1:0] word
);
    localparam int PH_W  = $clog2(HALF + 1);
    localparam int BIT_W = $clog2(NBITS + 1);

    logic             active;
    logic             sclk_q;
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bits;
    logic [OUT_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk_q <= 1'b0;
            ph     <= '0;
            bits   <= '0;
            shreg  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sclk_q <= 1'b0;
                ph     <= '0;
                bits   <= '0;
            end else if (active) begin
                if (ph == PH_W'(HALF - 1)) begin
                    ph <= '0;
                    if (!sclk_q) begin
                        // rising edge: capture the bit the converter presents
                        sclk_q <= 1'b1;
                        shreg  <= {shreg[OUT_W-2:0], sdata};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bits == BIT_W'(NBITS - 1)) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bits <= bits + 1'b1;
                        end
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign word = shreg;
endmodule

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer #(
    parameter int PW         = 16,
    parameter int MIN_PERIOD = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [PW-1:0] period,
    output logic          due
);
    localparam logic [PW-1:0] MIN_P = PW'(MIN_PERIOD);

    logic [PW-1:0] cnt;
    logic [PW-1:0] eff;

    always_comb begin
        eff = (period < MIN_P) ? MIN_P : period;
        due = (cnt >= eff - 1'b1);
    end

    // Counts cycles since the last accepted start; saturates when idle long
    always_ff @(posedge clk) begin
        if (rst)              cnt <= '1;
        else if (go)          cnt <= '0;
        else if (cnt != '1)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int T_LOW       = 5,
    parameter int T_WAKE      = 400,
    parameter int T_CONV      = 380,
    parameter int SCLK_HALF   = 4,
    parameter int T_QUIET     = 32,
    parameter int BUSY_TMO    = 1200,
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16,
    parameter int SAMPLE_W    = 12,
    parameter int PERIOD_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic                run_en,
    input  logic                sleep_mode,
    input  logic [PERIOD_W-1:0] run_period,
    input  logic                busy,
    input  logic                sdata,
    output logic                convst,
    output logic                sclk,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_vld,
    output logic                conv_err
);
    localparam int MIN_PERIOD = T_LOW + T_CONV + 2 * SCLK_HALF * FRAME_BITS + T_QUIET;
    localparam int TMR_MAX    = umax(umax(T_LOW, T_WAKE), umax(T_QUIET, BUSY_TMO));
    localparam int TMR_W      = $clog2(TMR_MAX + 1);

    seq_state_t          state;
    pwr_mode_t           mode_q;
    logic                convst_q;
    logic [TMR_W-1:0]    tmr;
    logic                seen_hi;
    logic                rd_go;
    conv_flags_t         flags;
    logic [SAMPLE_W-1:0] sample_q;

    logic                busy_s;
    logic                pace_due;
    logic                rd_done;
    logic [SAMPLE_W-1:0] rd_word;
    logic                go;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk (clk),
        .rst (rst),
        .d   (busy),
        .q   (busy_s)
    );

    adc_seq_pacer #(.PW(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .period (run_period),
        .due    (pace_due)
    );

    adc_seq_shift #(.HALF(SCLK_HALF), .NBITS(FRAME_BITS), .OUT_W(SAMPLE_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .go    (rd_go),
        .sdata (sdata),
        .sclk  (sclk),
        .done  (rd_done),
        .word  (rd_word)
    );

    assign go = (state == ST_IDLE) && (start_req || (run_en && pace_due));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= MODE_FAST;
            convst_q <= idle_level(MODE_FAST);
            tmr      <= '0;
            seen_hi  <= 1'b0;
            rd_go    <= 1'b0;
            flags    <= '0;
            sample_q <= '0;
        end else begin
            rd_go     <= 1'b0;
            flags.vld <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        mode_q    <= pwr_mode_t'(sleep_mode);
                        flags.err <= 1'b0;
                        tmr       <= '0;
                        if (sleep_mode) begin
                            convst_q <= 1'b1;
                            state    <= ST_WAKE;
                        end else if (!convst_q) begin
                            convst_q <= 1'b1;
                            state    <= ST_ARM;
                        end else begin
                            convst_q <= 1'b0;
                            state    <= ST_LOW;
                        end
                    end
                end
                ST_ARM: begin
                    if (tmr == TMR_W'(T_LOW - 1)) begin
                        tmr      <= '0;
                        convst_q <= 1'b0;
                        state    <= ST_LOW;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tmr == TMR_W'(T_LOW - 1)) begin
                        tmr      <= '0;
                        seen_hi  <= 1'b0;
                        convst_q <= 1'b1;
                        state    <= ST_WAIT;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (tmr == TMR_W'(T_WAKE - 1)) begin
                        tmr      <= '0;
                        seen_hi  <= 1'b0;
                        convst_q <= 1'b0;
                        state    <= ST_WAIT;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_WAIT: begin
                    tmr <= tmr + 1'b1;
                    if (busy_s) seen_hi <= 1'b1;
                    if (seen_hi && !busy_s) begin
                        rd_go <= 1'b1;
                        state <= ST_READ;
                    end else if (tmr == TMR_W'(BUSY_TMO - 1)) begin
                        flags.err <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (rd_done) begin
                        sample_q  <= rd_word;
                        flags.vld <= 1'b1;
                        tmr       <= '0;
                        state     <= ST_QUIET;
                    end
                end
                ST_QUIET: begin
                    if (tmr == TMR_W'(T_QUIET - 1)) begin
                        tmr   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign convst     = convst_q;
    assign sample     = sample_q;
    assign sample_vld = flags.vld;
    assign conv_err   = flags.err;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int T_LOW   = 5,
    parameter int T_QUIET = 32
) (
    input logic clk,
    input logic rst,
    input logic convst,
    input logic sclk,
    input logic busy,
    input logic sample_vld,
    input logic conv_err
);
    logic [15:0] lo_cnt;
    logic [15:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt  <= '0;
            gap_cnt <= '1;
        end else begin
            if (convst)               lo_cnt <= '0;
            else if (lo_cnt != '1)    lo_cnt <= lo_cnt + 1'b1;
            if (sclk)                 gap_cnt <= '0;
            else if (gap_cnt != '1)   gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(convst) |-> (lo_cnt >= 16'(T_LOW)));

    // R4
    no_sclk_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sclk);

    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> !sample_vld);

    // R7
    quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(convst) |-> (gap_cnt >= 16'(T_QUIET)));

    // R8
    convst_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk || $past(sclk)) |-> $stable(convst));

    // R9
    err_no_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_err) |-> !sample_vld);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.T_LOW(T_LOW), .T_QUIET(T_QUIET)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .convst     (convst),
    .sclk       (sclk),
    .busy       (busy),
    .sample_vld (sample_vld),
    .conv_err   (conv_err)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int T_LOW     = 3;
    localparam int T_WAKE    = 10;
    localparam int T_CONV    = 20;
    localparam int SCLK_HALF = 2;
    localparam int T_QUIET   = 6;
    localparam int BUSY_TMO  = 60;
    localparam int PERIOD_W  = 12;
    localparam int CNV_BUSY  = 20;
    localparam int MIN_P     = T_LOW + T_CONV + 32 * SCLK_HALF + T_QUIET;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst = 1'b1;
    logic                start_req = 1'b0;
    logic                run_en = 1'b0;
    logic                sleep_mode = 1'b0;
    logic [PERIOD_W-1:0] run_period = '0;
    logic                busy = 1'b0;
    logic                sdata = 1'b0;
    logic                convst;
    logic                sclk;
    logic [11:0]         sample;
    logic                sample_vld;
    logic                conv_err;

    adc_seq_ctrl #(
        .T_LOW(T_LOW), .T_WAKE(T_WAKE), .T_CONV(T_CONV), .SCLK_HALF(SCLK_HALF),
        .T_QUIET(T_QUIET), .BUSY_TMO(BUSY_TMO), .PERIOD_W(PERIOD_W)
    ) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .run_en(run_en),
        .sleep_mode(sleep_mode), .run_period(run_period), .busy(busy),
        .sdata(sdata), .convst(convst), .sclk(sclk), .sample(sample),
        .sample_vld(sample_vld), .conv_err(conv_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_spacing(input int p);
        return (p < MIN_P) ? MIN_P : p;
    endfunction

    function automatic int exp_sample(input logic [15:0] w);
        return int'(w[11:0]);
    endfunction

    // ---------------- converter model and monitors (negedge) ----------------
    int          cyc = 0;
    bit          stuck = 1'b0;
    logic        prev_cv = 1'b1;
    logic        prev_sk = 1'b0;
    int          run_lo = 0, run_hi = 0, last_low = 0, last_high = 0;
    int          bcnt = 0;
    logic [15:0] cnv_word = '0;
    int          idx = 0;
    int          nrise = 0;
    int          sclk_busy = 0;
    logic        cv_at_end = 1'b0;
    int          sclk_fall_cyc = 0;
    bit          have_read = 1'b0;
    int          fall_cnt = 0, last_fall_cyc = 0, last_interval = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!prev_cv && convst) last_low = run_lo;
            if (prev_cv && !convst) begin
                last_high     = run_hi;
                last_interval = cyc - last_fall_cyc;
                last_fall_cyc = cyc;
                fall_cnt++;
                if (have_read)   // R7
                    chk((cyc - sclk_fall_cyc) >= T_QUIET, "R7 quiet gap",
                        cyc - sclk_fall_cyc, T_QUIET);
                busy      = 1'b1;
                bcnt      = CNV_BUSY;
                sclk_busy = 0;
            end else if (busy && !stuck) begin
                if (bcnt == 0) begin
                    busy      = 1'b0;
                    cv_at_end = convst;
                    cnv_word  = 16'($urandom);
                    idx       = 15;
                    sdata     = cnv_word[15];
                    nrise     = 0;
                end else begin
                    bcnt--;
                end
            end
            if (convst != prev_cv) begin run_lo = 0; run_hi = 0; end
            if (convst) run_hi++; else run_lo++;
            if (!prev_sk && sclk) begin
                nrise++;
                if (busy) sclk_busy++;
            end
            if (prev_sk && !sclk) begin
                sclk_fall_cyc = cyc;
                have_read     = 1'b1;
                if (idx > 0) idx--;
                sdata = cnv_word[idx];
            end
            if (sample_vld)   // R6
                chk(int'(sample) == exp_sample(cnv_word), "R6 sample value",
                    int'(sample), exp_sample(cnv_word));
            prev_cv = convst;
            prev_sk = sclk;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- directed and random conversions ----------------
    bit prev_sleep = 1'b0;

    task automatic do_conv(input bit mode, input bit flip);
        bit got = 1'b0;
        @(negedge clk);
        sleep_mode = mode;
        start_req  = 1'b1;
        @(negedge clk);
        start_req  = 1'b0;
        if (flip) sleep_mode = ~mode;   // R11: must not affect this conversion
        for (int i = 0; i < 2000 && !got; i++) begin
            @(negedge clk);
            if (sample_vld || conv_err) got = 1'b1;
        end
        chk(sample_vld == 1'b1, "R6 strobe seen", int'(sample_vld), 1);
        chk(conv_err == 1'b0, "R9 error clear on normal run", int'(conv_err), 0);
        chk(nrise == 16, "R5 sclk count", nrise, 16);
        chk(sclk_busy == 0, "R4 sclk during busy", sclk_busy, 0);
        if (!mode) begin
            chk(cv_at_end == 1'b1, "R2 convst high at end R11", int'(cv_at_end), 1);
            chk(last_low == T_LOW, "R2 start pulse width", last_low, T_LOW);
        end else begin
            chk(cv_at_end == 1'b0, "R3 convst low at end R11", int'(cv_at_end), 0);
            if (prev_sleep)
                chk(last_high == T_WAKE, "R3 wake width", last_high, T_WAKE);
        end
        @(negedge clk);
        chk(sample_vld == 1'b0, "R6 single-cycle strobe", int'(sample_vld), 0);
        repeat (T_QUIET + 4) @(negedge clk);
        chk(convst == (mode ? 1'b0 : 1'b1), "R3 R2 idle level", int'(convst), mode ? 0 : 1);
        prev_sleep = mode;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1
        chk(convst == 1'b1 && sclk == 1'b0 && sample_vld == 1'b0 && conv_err == 1'b0,
            "R1 values in reset", {convst, sclk, sample_vld, conv_err}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(convst == 1'b1 && sclk == 1'b0 && sample_vld == 1'b0 && conv_err == 1'b0,
            "R1 values after reset", {convst, sclk, sample_vld, conv_err}, 4'b1000);

        // directed: every mode transition
        do_conv(1'b0, 1'b0);
        do_conv(1'b0, 1'b0);
        do_conv(1'b1, 1'b0);
        do_conv(1'b1, 1'b0);
        do_conv(1'b0, 1'b1);
        do_conv(1'b1, 1'b1);
        do_conv(1'b0, 1'b0);

        // random mix
        for (int k = 0; k < 16; k++) begin
            bit m = 1'($urandom);
            bit f = ($urandom % 4) == 0;
            do_conv(m, f);
        end

        // R9: busy held high
        begin
            int  waited = 0;
            bit  vld_seen = 1'b0;
            bit  got = 1'b0;
            @(negedge clk);
            stuck      = 1'b1;
            sleep_mode = 1'b0;
            start_req  = 1'b1;
            @(negedge clk);
            start_req  = 1'b0;
            for (int i = 0; i < 500 && !got; i++) begin
                @(negedge clk);
                waited++;
                if (sample_vld) vld_seen = 1'b1;
                if (conv_err) got = 1'b1;
            end
            chk(got, "R9 timeout flag", int'(got), 1);
            chk(waited >= BUSY_TMO, "R9 timeout not early", waited, BUSY_TMO);
            chk(!vld_seen, "R9 no sample on timeout", int'(vld_seen), 0);
            repeat (5) @(negedge clk);
            chk(sclk == 1'b0 && conv_err == 1'b1, "R9 idle after timeout",
                {sclk, conv_err}, 2'b01);
            stuck = 1'b0;
            repeat (CNV_BUSY + 10) @(negedge clk);
            prev_sleep = 1'b0;
            do_conv(1'b0, 1'b0);   // also confirms conv_err cleared by the new start
        end

        // R10: continuous running
        begin
            int f0;
            sleep_mode = 1'b0;
            run_period = PERIOD_W'(200);
            run_en     = 1'b1;
            f0 = fall_cnt;
            while (fall_cnt < f0 + 2) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                int fk = fall_cnt;
                while (fall_cnt == fk) @(negedge clk);
                chk(last_interval == exp_spacing(200), "R10 programmed spacing",
                    last_interval, exp_spacing(200));
            end
            run_period = PERIOD_W'(5);
            f0 = fall_cnt;
            while (fall_cnt < f0 + 2) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                int fk = fall_cnt;
                while (fall_cnt == fk) @(negedge clk);
                chk(last_interval >= exp_spacing(5), "R10 throughput floor",
                    last_interval, exp_spacing(5));
            end
            run_en = 1'b0;
            repeat (300) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule